// File: doc/BRIEF.md
# Galois LFSR Programmable Cycle Counter

This block measures out a programmable number of enabled clock ticks with an 11-bit Galois shift register in place of a binary counter. Software or an upstream stage does not program a binary length. It loads a register state, and the counter shifts from that state toward a fixed end state. The number of steps it takes equals the distance along the register sequence. Reaching the end state raises a terminal flag. A reserved all-zero state means "zero length", so a zero load cannot leave the register stuck.

A companion translator turns a binary table position into the matching starting state. It does this by walking the sequence from the all-ones state, one step per clock. Positions enter and states leave on valid/ready streams. The translator takes a position only while it is idle (`pos_ready` high). It holds a finished state on `seed_data` with `seed_valid` high until `seed_ready` is seen high at a clock edge, and only then returns to idle. The two halves are independent, so the user feeds `seed_data` into `load_state` as the surrounding logic requires.

Top module: `lfsr_cycle_counter`

## Requirements
- R1: After reset, `cur_state` is 0x7FF, `tc` is high, `pos_ready` is high and `seed_valid` is low.
- R2: When `step_en` is high, `load_en` is low and `tc` is low, the next `cur_state` is `cur_state >> 1` if bit 0 is 0. If bit 0 is 1, it is `(cur_state >> 1) ^ 0x500`.
- R3: With `load_en` and `step_en` both low, `cur_state` holds its value.
- R4: When `load_en` is high, the next `cur_state` equals `load_state`, whatever `step_en` is.
- R5: `tc` is high exactly when `cur_state` is 0x7FF or 0. Position i (1..2047) holds the state reached from 0x7FF after 2048−i steps. After loading the state of position i, `tc` rises after exactly i−1 enabled steps.
- R6: While `tc` is high and `load_en` is low, `step_en` has no effect on `cur_state`.
- R7: Loading 0 raises `tc` on the next cycle. The register stays at 0 under stepping, and a later load of any other state resumes normal counting.
- R8: The step rule of R2 visits 2047 distinct nonzero states from 0x7FF before it returns to 0x7FF.
- R9: The translator accepts a position p when `pos_valid` and `pos_ready` are both high at a clock edge. It returns 0 for p = 0, and otherwise the state of position p as defined in R5.
- R10: `seed_valid` rises 2048−p clock edges after the accepting edge for p ≥ 1. For p = 0 it rises at the accepting edge itself.
- R11: While `seed_valid` is high and `seed_ready` is low, `seed_data` holds and `pos_ready` stays low, and `pos_valid` is ignored. A high `seed_ready` at an edge ends the transfer and raises `pos_ready` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load `load_state` into the counter |
| load_state | input | 11 | Starting state to load |
| step_en | input | 1 | Advance the counter one step |
| cur_state | output | 11 | Present counter state |
| tc | output | 1 | Terminal: state is 0x7FF or 0 |
| pos_valid | input | 1 | Position stream valid |
| pos_ready | output | 1 | Translator idle, position accepted |
| pos_data | input | 11 | Binary table position |
| seed_valid | output | 1 | Translated state available |
| seed_ready | input | 1 | Consumer takes the translated state |
| seed_data | output | 11 | Translated starting state |

## Verification
The bench builds the block with its default parameters: an 11-bit register, tap mask 0x500 and an all-ones end state. At this size a full period of 2047 states takes only a few thousand cycles. That makes it affordable to translate both extreme positions, 1 and 2047, and count them down to terminal step by step, comparing every state. The same width lets the reference model walk the complete period and confirm that no state repeats. The zero position and back-pressure on the result stream are exercised at the same width.

// File: rtl/lfsr_cnt_pkg.sv
package lfsr_cnt_pkg;
  localparam int DEF_WIDTH = 11;
  localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 11'h500;

  typedef enum logic [1:0] {
    XL_IDLE = 2'd0,
    XL_RUN  = 2'd1,
    XL_DONE = 2'd2
  } xlat_phase_t;
endpackage

// File: rtl/lfsr_advance.sv
module lfsr_advance #(
  parameter int WIDTH = 11,
  parameter logic [WIDTH-1:0] TAP_MASK = 'h500
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  // Right-shifting Galois form: the bit falling out of position 0 is fed back
  // into every tapped position.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (b == WIDTH - 1) begin : g_top
      assign nxt[b] = TAP_MASK[b] & cur[0];
    end else begin : g_mid
      assign nxt[b] = cur[b+1] ^ (TAP_MASK[b] & cur[0]);
    end
  end
endmodule

// File: rtl/lfsr_tc_detect.sv
module lfsr_tc_detect #(
  parameter int WIDTH = 11
) (
  input  logic [WIDTH-1:0] state,
  output logic             tc
);
  localparam logic [WIDTH-1:0] END_STATE = '1;

  logic at_end;
  logic at_zero;

  assign at_end  = (state == END_STATE);
  assign at_zero = ~|state;
  assign tc      = at_end | at_zero;
endmodule

// File: rtl/lfsr_count_core.sv
module lfsr_count_core #(
  parameter int WIDTH = 11,
  parameter logic [WIDTH-1:0] TAP_MASK = 'h500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_state,
  input  logic             step_en,
  output logic [WIDTH-1:0] state,
  output logic             tc
);
  localparam logic [WIDTH-1:0] END_STATE = '1;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;
  logic             tc_w;

  lfsr_advance #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_adv (
    .cur (state_q),
    .nxt (state_nxt)
  );

  lfsr_tc_detect #(.WIDTH(WIDTH)) u_tc (
    .state (state_q),
    .tc    (tc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= END_STATE;
    end else if (load_en) begin
      state_q <= load_state;
    end else if (step_en && !tc_w) begin
      state_q <= state_nxt;
    end
  end

  assign state = state_q;
  assign tc    = tc_w;
endmodule

// File: rtl/lfsr_seed_xlat.sv
module lfsr_seed_xlat
  import lfsr_cnt_pkg::*;
#(
  parameter int WIDTH = 11,
  parameter logic [WIDTH-1:0] TAP_MASK = 'h500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_valid,
  output logic             pos_ready,
  input  logic [WIDTH-1:0] pos_data,
  output logic             seed_valid,
  input  logic             seed_ready,
  output logic [WIDTH-1:0] seed_data
);
  localparam logic [WIDTH-1:0] END_STATE = '1;
  localparam logic [WIDTH-1:0] CNT_ONE   = WIDTH'(1);

  xlat_phase_t      phase_q;
  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] work_nxt;
  logic [WIDTH-1:0] remain_q;

  lfsr_advance #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_adv (
    .cur (work_q),
    .nxt (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= XL_IDLE;
      work_q   <= END_STATE;
      remain_q <= '0;
    end else begin
      unique case (phase_q)
        XL_IDLE: begin
          if (pos_valid) begin
            if (pos_data == '0) begin
              work_q  <= '0;
              phase_q <= XL_DONE;
            end else begin
              // Steps needed: 2^WIDTH - p, which the modular negation yields.
              work_q   <= END_STATE;
              remain_q <= '0 - pos_data;
              phase_q  <= XL_RUN;
            end
          end
        end
        XL_RUN: begin
          work_q <= work_nxt;
          if (remain_q == CNT_ONE) begin
            phase_q <= XL_DONE;
          end else begin
            remain_q <= remain_q - CNT_ONE;
          end
        end
        XL_DONE: begin
          if (seed_ready) phase_q <= XL_IDLE;
        end
        default: phase_q <= XL_IDLE;
      endcase
    end
  end

  assign pos_ready  = (phase_q == XL_IDLE);
  assign seed_valid = (phase_q == XL_DONE);
  assign seed_data  = work_q;
endmodule

// File: rtl/lfsr_cycle_counter.sv
module lfsr_cycle_counter #(
  parameter int WIDTH = 11,
  parameter logic [WIDTH-1:0] TAP_MASK = 'h500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_state,
  input  logic             step_en,
  output logic [WIDTH-1:0] cur_state,
  output logic             tc,
  input  logic             pos_valid,
  output logic             pos_ready,
  input  logic [WIDTH-1:0] pos_data,
  output logic             seed_valid,
  input  logic             seed_ready,
  output logic [WIDTH-1:0] seed_data
);
  lfsr_count_core #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_state (load_state),
    .step_en    (step_en),
    .state      (cur_state),
    .tc         (tc)
  );

  lfsr_seed_xlat #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_xlat (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_valid  (pos_valid),
    .pos_ready  (pos_ready),
    .pos_data   (pos_data),
    .seed_valid (seed_valid),
    .seed_ready (seed_ready),
    .seed_data  (seed_data)
  );
endmodule

// File: rtl/lfsr_cycle_counter_chk.sv
module lfsr_cycle_counter_chk #(
  parameter int WIDTH = 11,
  parameter logic [WIDTH-1:0] TAP_MASK = 'h500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [WIDTH-1:0] load_state,
  input logic             step_en,
  input logic [WIDTH-1:0] cur_state,
  input logic             tc,
  input logic             pos_ready,
  input logic             seed_valid,
  input logic             seed_ready,
  input logic [WIDTH-1:0] seed_data
);
  p_shift_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !tc && !cur_state[0]) |=> (cur_state == ($past(cur_state) >> 1)));

  p_shift_odd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !tc && cur_state[0]) |=> (cur_state == (($past(cur_state) >> 1) ^ TAP_MASK)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step_en) |=> $stable(cur_state));

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cur_state == $past(load_state)));

  p_tc_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !load_en) |=> $stable(cur_state));

  p_zero_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_state == '0) && !load_en) |=> ((cur_state == '0) && tc));

  p_seed_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_valid && !seed_ready) |=> (seed_valid && $stable(seed_data)));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |-> !pos_ready);
endmodule

bind lfsr_cycle_counter lfsr_cycle_counter_chk #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_en    (load_en),
  .load_state (load_state),
  .step_en    (step_en),
  .cur_state  (cur_state),
  .tc         (tc),
  .pos_ready  (pos_ready),
  .seed_valid (seed_valid),
  .seed_ready (seed_ready),
  .seed_data  (seed_data)
);

// File: tb/sim_lfsr_cycle_counter.sv
`timescale 1ns/1ps
module sim_lfsr_cycle_counter;
  localparam int W = 11;
  localparam int NV = 8;
  localparam int VPOS   [NV] = '{0, 1, 2, 3, 100, 1000, 2046, 2047};
  localparam int VSTEPS [NV] = '{0, 0, 1, 2, 99, 999, 2045, 2046};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_en = 1'b0;
  logic [W-1:0] load_state = '0;
  logic         step_en = 1'b0;
  logic [W-1:0] cur_state;
  logic         tc;
  logic         pos_valid = 1'b0;
  logic         pos_ready;
  logic [W-1:0] pos_data = '0;
  logic         seed_valid;
  logic         seed_ready = 1'b0;
  logic [W-1:0] seed_data;

  int checks = 0;
  int errors = 0;
  bit seen [0:2047];

  always #10 clk = ~clk;

  lfsr_cycle_counter u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_state(load_state),
    .step_en(step_en), .cur_state(cur_state), .tc(tc),
    .pos_valid(pos_valid), .pos_ready(pos_ready), .pos_data(pos_data),
    .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] s);
    if (s[0]) return (s >> 1) ^ 11'h500;
    return s >> 1;
  endfunction

  function automatic logic [W-1:0] ref_seed(input int p);
    logic [W-1:0] s = 11'h7FF;
    if (p == 0) return '0;
    for (int k = 0; k < 2048 - p; k++) s = ref_next(s);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Sends p, measures latency, returns the state and completes the transfer.
  task automatic translate(input int p, output logic [W-1:0] res, output int lat);
    pos_data = W'(p);
    pos_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pos_valid = 1'b0;
    lat = 0;
    while (!seed_valid && lat < 4000) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    res = seed_data;
    seed_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seed_ready = 1'b0;
  endtask

  task automatic load(input logic [W-1:0] s);
    load_state = s;
    load_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] res;
    logic [W-1:0] expst;
    logic [W-1:0] hold;
    int lat;
    int steps;
    int distinct;
    bit dup;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cur_state == 11'h7FF, "R1 cur_state", cur_state, 11'h7FF);
    chk(tc == 1'b1, "R1 tc", tc, 1);
    chk(pos_ready == 1'b1, "R1 pos_ready", pos_ready, 1);
    chk(seed_valid == 1'b0, "R1 seed_valid", seed_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: translate each position, load, count to terminal.
    for (int v = 0; v < NV; v++) begin
      translate(VPOS[v], res, lat);
      chk(res == ref_seed(VPOS[v]), "R9 seed", res, ref_seed(VPOS[v]));
      chk(lat == ((VPOS[v] == 0) ? 0 : 2048 - VPOS[v]), "R10 latency", lat,
          (VPOS[v] == 0) ? 0 : 2048 - VPOS[v]);
      chk(pos_ready == 1'b1 && seed_valid == 1'b0, "R11 release", pos_ready, 1);
      load(res);
      chk(cur_state == res, "R4 load", cur_state, res);
      expst = res;
      steps = 0;
      step_en = 1'b1;
      while (!tc && steps < 3000) begin
        @(posedge clk);
        @(negedge clk);
        steps++;
        expst = ref_next(expst);
        chk(cur_state == expst, "R2 step", cur_state, expst);
      end
      step_en = 1'b0;
      chk(steps == VSTEPS[v], "R5 steps to tc", steps, VSTEPS[v]);
    end

    // R3: hold without enables
    load(11'h123);
    repeat (3) @(negedge clk);
    chk(cur_state == 11'h123, "R3 hold", cur_state, 11'h123);
    chk(tc == 1'b0, "R5 tc low mid-count", tc, 0);

    // R4: load beats step in the same cycle
    step_en = 1'b1;
    load(11'h2AA);
    step_en = 1'b0;
    chk(cur_state == 11'h2AA, "R4 load priority", cur_state, 11'h2AA);

    // R6: stepping at terminal has no effect
    load(11'h7FF);
    chk(tc == 1'b1, "R5 tc at end", tc, 1);
    step_en = 1'b1;
    repeat (4) @(negedge clk);
    step_en = 1'b0;
    chk(cur_state == 11'h7FF, "R6 frozen at terminal", cur_state, 11'h7FF);

    // R7: zero state
    load(11'h000);
    chk(tc == 1'b1, "R7 zero tc", tc, 1);
    step_en = 1'b1;
    repeat (4) @(negedge clk);
    step_en = 1'b0;
    chk(cur_state == 11'h000, "R7 zero stays", cur_state, 0);
    load(11'h123);
    chk(tc == 1'b0 && cur_state == 11'h123, "R7 recover", cur_state, 11'h123);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    chk(cur_state == ref_next(11'h123), "R7 counts again", cur_state, ref_next(11'h123));

    // R8: reference period walk
    expst = 11'h7FF;
    dup = 1'b0;
    distinct = 1;
    for (int i = 0; i < 2048; i++) seen[i] = 1'b0;
    seen[11'h7FF] = 1'b1;
    for (int k = 1; k <= 2047; k++) begin
      expst = ref_next(expst);
      if (k < 2047) begin
        if (seen[expst] || expst == '0) dup = 1'b1;
        else distinct++;
        seen[expst] = 1'b1;
      end
    end
    chk(!dup && distinct == 2047, "R8 distinct states", distinct, 2047);
    chk(expst == 11'h7FF, "R8 period return", expst, 11'h7FF);

    // R11: back-pressure and ignored input while busy
    pos_data = 11'd2040;
    pos_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pos_data = 11'd5;
    chk(pos_ready == 1'b0, "R11 busy", pos_ready, 0);
    while (!seed_valid) @(negedge clk);
    hold = seed_data;
    repeat (5) @(negedge clk);
    pos_valid = 1'b0;
    chk(seed_valid == 1'b1 && seed_data == hold, "R11 stall hold", seed_data, hold);
    chk(hold == ref_seed(2040), "R11 busy input ignored", hold, ref_seed(2040));
    chk(pos_ready == 1'b0, "R11 not ready while stalled", pos_ready, 0);
    seed_ready = 1'b1;
    @(negedge clk);
    seed_ready = 1'b0;
    chk(seed_valid == 1'b0 && pos_ready == 1'b1, "R11 handoff", pos_ready, 1);

    finish_run();
  end
endmodule